// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is the configuration-space front end of a multi-function I/O controller. A host reaches it through two byte-wide I/O locations: an index location at `BASE_ADDR` and a data location at `BASE_ADDR + 1`. After reset the space is closed. It opens only when the unlock key byte has been written to the index location twice in a row. A separate lock key byte closes it again.

While the space is open, an index write selects a configuration register, and data-location reads and writes reach that register. The block holds a few global registers itself: a bank selector, read-only identification bytes and a revision byte. It also holds one enable bit for each logical device, and the bank selector chooses which device's enable bit is visible. Register indices from 0x31 upward belong to the selected logical device. The block forwards them unchanged over a simple register-file strobe interface, tagged with the current bank number.

Top module: `cfgp_keyed_port`

## Requirements
- R1: After reset the space is closed, the selected bank is 0, every device enable bit is 0, and data-location reads return 0xFF.
- R2: The space opens only after two successive index-location writes of the unlock key 0x87, and it is open from the clock edge after the second one.
- R3: While closed, any index write other than the key restarts the sequence. A data-location access between the two key writes also restarts it. A single key write followed by any other index value leaves the space closed.
- R4: While open, an index write of 0x AA-valued lock key (0xAA) closes the space from the next clock edge. It does not change the selected register.
- R5: While closed, data-location reads return 0xFF, index-location reads return 0xFF, and data-location writes change no register and raise no downstream write strobe.
- R6: While open, any index write other than 0xAA selects that register, and a read of the index location returns the selected index.
- R7: Register 0x07 is a read/write bank selector that holds the logical device number, for example 0x07 for the watchdog. Its value appears on `cur_ldn`.
- R8: Registers 0x20 and 0x21 return the high and low bytes of `DEV_ID`. Register 0x22 returns `DEV_REV`. Registers 0x23 and 0x24 return the high and low bytes of the manufacturer ID 0x1934. Writes to these five registers are ignored.
- R9: Bit 0 of register 0x30 is the enable bit of the selected logical device, and bits 7:1 read as 0. When the selected bank number is not below `NUM_LDN`, the register reads 0x00 and writes are ignored. Each device's bit appears on `ldn_enable`.
- R10: While open, data accesses to indices 0x31 to 0xFF pulse `dev_wr` or `dev_rd` in the same cycle, with `dev_addr` set to the index, and a read returns `dev_rdata`. No other access raises these strobes.
- R11: Accesses to any other I/O address are ignored and read 0x00. Global indices below 0x30 that are not otherwise defined read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Host read byte, valid in the cycle of `io_rd` |
| cfg_open | output | 1 | Configuration space is unlocked |
| cur_ldn | output | 8 | Selected logical device number |
| ldn_enable | output | NUM_LDN | Enable bit of each logical device |
| dev_wr | output | 1 | Write strobe to the selected device's registers |
| dev_rd | output | 1 | Read strobe to the selected device's registers |
| dev_addr | output | 8 | Register index for the device access |
| dev_wdata | output | 8 | Write byte for the device access |
| dev_rdata | input | 8 | Read byte from the selected device |

## Verification
The key sequence is tried with two back-to-back key writes, a key followed by another index value, a key interrupted by a data access, and a lock write followed by an attempt to reopen. These patterns separate a correct two-step unlock from a one-step unlock or a sequence that never restarts. Random streams mix index values that are often the key or the lock byte with register indices spread over the global, identification, enable and forwarded ranges. They also include bank numbers above `NUM_LDN`. Together these show whether read-only registers stay fixed, whether each device's enable bit is stored in its own bank, and whether forwarding starts exactly at 0x31. Directed writes with the space closed confirm that nothing changes at the outputs.

// File: rtl/cfgp_pkg.sv
// Package: shared register indices and lock-state encoding for the keyed
// configuration port. Assumes 8-bit register indices.
package cfgp_pkg;
    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_e;

    localparam logic [7:0] IDX_LDN    = 8'h07;
    localparam logic [7:0] IDX_DEVHI  = 8'h20;
    localparam logic [7:0] IDX_DEVLO  = 8'h21;
    localparam logic [7:0] IDX_REV    = 8'h22;
    localparam logic [7:0] IDX_MFRHI  = 8'h23;
    localparam logic [7:0] IDX_MFRLO  = 8'h24;
    localparam logic [7:0] IDX_ENABLE = 8'h30;
    localparam logic [7:0] IDX_FWD_LO = 8'h31;
    localparam logic [7:0] CLOSED_BYTE = 8'hFF;
endpackage

// File: rtl/cfgp_key_fsm.sv
// Module: cfgp_key_fsm
// Tracks the unlock sequence (two successive key writes) and the lock key.
// It also holds the selected register index. Assumes each strobe lasts one
// cycle and that the caller has already decoded the index and data locations.
module cfgp_key_fsm
    import cfgp_pkg::*;
#(
    parameter logic [7:0] UNLOCK_KEY = 8'h87,
    parameter logic [7:0] LOCK_KEY   = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       data_acc,
    input  logic [7:0] wdata,
    output logic       open,
    output logic [7:0] idx_q
);
    key_state_e state_q, state_d;

    // Next lock state from index writes and data accesses.
    always_comb begin
        state_d = state_q;
        case (state_q)
            KS_LOCKED: if (idx_wr) state_d = (wdata == UNLOCK_KEY) ? KS_HALF : KS_LOCKED;
            KS_HALF: begin
                if (idx_wr)        state_d = (wdata == UNLOCK_KEY) ? KS_OPEN : KS_LOCKED;
                else if (data_acc) state_d = KS_LOCKED;
            end
            KS_OPEN:   if (idx_wr && wdata == LOCK_KEY) state_d = KS_LOCKED;
            default:   state_d = KS_LOCKED;
        endcase
    end

    // Lock state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KS_LOCKED;
        else        state_q <= state_d;
    end

    // Register index: loaded by index writes only while open.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= 8'h00;
        else if (state_q == KS_OPEN && idx_wr && wdata != LOCK_KEY)
            idx_q <= wdata;
    end

    assign open = (state_q == KS_OPEN);
endmodule

// File: rtl/cfgp_id_rom.sv
// Module: cfgp_id_rom
// Read-only identification bytes: device ID, revision and manufacturer ID.
// In each 16-bit pair the high byte sits at the lower index. Purely
// combinational; holds no state, so writes have nowhere to land.
module cfgp_id_rom
    import cfgp_pkg::*;
#(
    parameter logic [15:0] DEV_ID  = 16'h5A31,
    parameter logic [7:0]  DEV_REV = 8'h03,
    parameter logic [15:0] MFR_ID  = 16'h1934
) (
    input  logic [7:0] idx,
    output logic       hit,
    output logic [7:0] rdata
);
    // Decode the identification indices.
    always_comb begin
        hit   = 1'b1;
        rdata = 8'h00;
        case (idx)
            IDX_DEVHI: rdata = DEV_ID[15:8];
            IDX_DEVLO: rdata = DEV_ID[7:0];
            IDX_REV:   rdata = DEV_REV;
            IDX_MFRHI: rdata = MFR_ID[15:8];
            IDX_MFRLO: rdata = MFR_ID[7:0];
            default:   hit   = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfgp_ldn_bank.sv
// Module: cfgp_ldn_bank
// Holds the logical-device-number selector and one enable bit per logical
// device. Assumes `wr` is already qualified with "space open, data write".
// Bank numbers at or above NUM_LDN select no enable bit.
module cfgp_ldn_bank
    import cfgp_pkg::*;
#(
    parameter int NUM_LDN = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [7:0]         idx,
    input  logic [7:0]         wdata,
    output logic [7:0]         ldn_q,
    output logic [NUM_LDN-1:0] en_q,
    output logic [7:0]         en_rdata
);
    logic [NUM_LDN-1:0] ldn_hit;

    // Bank selector register.
    always_ff @(posedge clk) begin
        if (!rst_n)                   ldn_q <= 8'h00;
        else if (wr && idx == IDX_LDN) ldn_q <= wdata;
    end

    // One enable flop per logical device, written only through its own bank.
    for (genvar g = 0; g < NUM_LDN; g++) begin : g_dev
        assign ldn_hit[g] = (ldn_q == 8'(g));
        always_ff @(posedge clk) begin
            if (!rst_n)                                   en_q[g] <= 1'b0;
            else if (wr && idx == IDX_ENABLE && ldn_hit[g]) en_q[g] <= wdata[0];
        end
    end

    // Readback of the selected device's enable bit; zero if no bank matches.
    always_comb begin
        en_rdata = 8'h00;
        for (int i = 0; i < NUM_LDN; i++)
            if (ldn_hit[i]) en_rdata[0] = en_q[i];
    end
endmodule

// File: rtl/cfgp_keyed_port.sv
// Module: cfgp_keyed_port (top)
// Keyed index/data configuration port. It decodes the two host I/O
// locations, gates access with the key sequence, serves the global registers
// and forwards per-device indices to the downstream register files.
// Assumes single-cycle host strobes and that io_wr and io_rd are never high
// together. Read data is combinational in the cycle of io_rd.
module cfgp_keyed_port
    import cfgp_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] BASE_ADDR  = 16'h002E,
    parameter int          NUM_LDN    = 16,
    parameter logic [7:0]  UNLOCK_KEY = 8'h87,
    parameter logic [7:0]  LOCK_KEY   = 8'hAA,
    parameter logic [15:0] DEV_ID     = 16'h5A31,
    parameter logic [7:0]  DEV_REV    = 8'h03,
    parameter logic [15:0] MFR_ID     = 16'h1934
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic [7:0]         io_wdata,
    output logic [7:0]         io_rdata,
    output logic               cfg_open,
    output logic [7:0]         cur_ldn,
    output logic [NUM_LDN-1:0] ldn_enable,
    output logic               dev_wr,
    output logic               dev_rd,
    output logic [7:0]         dev_addr,
    output logic [7:0]         dev_wdata,
    input  logic [7:0]         dev_rdata
);
    localparam logic [ADDR_W-1:0] IDX_LOC = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] DAT_LOC = ADDR_W'(BASE_ADDR) + ADDR_W'(1);

    logic       sel_idx, sel_dat;
    logic       open;
    logic [7:0] idx_q;
    logic       id_hit;
    logic [7:0] id_rdata;
    logic [7:0] en_rdata;
    logic       fwd_range;
    logic [7:0] cfg_rdata;

    // Host address decode.
    assign sel_idx = (io_addr == IDX_LOC);
    assign sel_dat = (io_addr == DAT_LOC);

    cfgp_key_fsm #(
        .UNLOCK_KEY (UNLOCK_KEY),
        .LOCK_KEY   (LOCK_KEY)
    ) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (io_wr & sel_idx),
        .data_acc ((io_wr | io_rd) & sel_dat),
        .wdata    (io_wdata),
        .open     (open),
        .idx_q    (idx_q)
    );

    cfgp_id_rom #(
        .DEV_ID  (DEV_ID),
        .DEV_REV (DEV_REV),
        .MFR_ID  (MFR_ID)
    ) u_id (
        .idx   (idx_q),
        .hit   (id_hit),
        .rdata (id_rdata)
    );

    cfgp_ldn_bank #(
        .NUM_LDN (NUM_LDN)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (open & io_wr & sel_dat),
        .idx      (idx_q),
        .wdata    (io_wdata),
        .ldn_q    (cur_ldn),
        .en_q     (ldn_enable),
        .en_rdata (en_rdata)
    );

    // Per-device indices go downstream.
    assign fwd_range = (idx_q >= IDX_FWD_LO);
    assign dev_wr    = open & io_wr & sel_dat & fwd_range;
    assign dev_rd    = open & io_rd & sel_dat & fwd_range;
    assign dev_addr  = idx_q;
    assign dev_wdata = io_wdata;

    // Register read data for the currently selected index.
    always_comb begin
        if (fwd_range)                cfg_rdata = dev_rdata;
        else if (idx_q == IDX_ENABLE) cfg_rdata = en_rdata;
        else if (idx_q == IDX_LDN)    cfg_rdata = cur_ldn;
        else if (id_hit)              cfg_rdata = id_rdata;
        else                          cfg_rdata = 8'h00;
    end

    // Host read mux: closed space reads all ones at both locations.
    always_comb begin
        io_rdata = 8'h00;
        if (io_rd && sel_idx)      io_rdata = open ? idx_q : CLOSED_BYTE;
        else if (io_rd && sel_dat) io_rdata = open ? cfg_rdata : CLOSED_BYTE;
    end

    assign cfg_open = open;
endmodule

// File: rtl/cfgp_checker.sv
// Module: cfgp_checker
// Temporal properties of the keyed configuration port, bound to the top.
// Observes ports plus the selected index held inside the key tracker.
module cfgp_checker #(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] BASE_ADDR  = 16'h002E,
    parameter int          NUM_LDN    = 16,
    parameter logic [7:0]  UNLOCK_KEY = 8'h87,
    parameter logic [7:0]  LOCK_KEY   = 8'hAA
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  io_addr,
    input logic               io_wr,
    input logic               io_rd,
    input logic [7:0]         io_wdata,
    input logic [7:0]         io_rdata,
    input logic               cfg_open,
    input logic [7:0]         cur_ldn,
    input logic [NUM_LDN-1:0] ldn_enable,
    input logic               dev_wr,
    input logic               dev_rd,
    input logic [7:0]         dev_addr,
    input logic [7:0]         idx_q
);
    localparam logic [ADDR_W-1:0] IDX_LOC = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] DAT_LOC = ADDR_W'(BASE_ADDR) + ADDR_W'(1);

    // R2: opening is always preceded by a key write to the index location.
    p_open_after_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(io_wr && io_addr == IDX_LOC && io_wdata == UNLOCK_KEY));

    // R4: the lock key closes the space on the next edge.
    p_lock_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && io_wr && io_addr == IDX_LOC && io_wdata == LOCK_KEY) |=> !cfg_open);

    // R5: closed space reads all ones at the data location.
    p_closed_reads_ff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && io_rd && io_addr == DAT_LOC) |-> io_rdata == 8'hFF);

    // R5: no downstream strobe while closed.
    p_closed_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |-> !(dev_wr || dev_rd));

    // R5: enables and bank hold while closed.
    p_closed_state_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> ($stable(ldn_enable) && $stable(cur_ldn)));

    // R7: the bank number changes only through a data write to index 0x07.
    p_ldn_write_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_open && io_wr && io_addr == DAT_LOC && idx_q == 8'h07) |=> $stable(cur_ldn));

    // R10: forwarded accesses are never below 0x31.
    p_fwd_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wr || dev_rd) |-> dev_addr >= 8'h31);

    // R10: a single strobe at a time.
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dev_wr, dev_rd}));
endmodule

bind cfgp_keyed_port cfgp_checker #(
    .ADDR_W     (ADDR_W),
    .BASE_ADDR  (BASE_ADDR),
    .NUM_LDN    (NUM_LDN),
    .UNLOCK_KEY (UNLOCK_KEY),
    .LOCK_KEY   (LOCK_KEY)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .cfg_open   (cfg_open),
    .cur_ldn    (cur_ldn),
    .ldn_enable (ldn_enable),
    .dev_wr     (dev_wr),
    .dev_rd     (dev_rd),
    .dev_addr   (dev_addr),
    .idx_q      (idx_q)
);

// File: tb/cfgp_keyed_port_tb.sv
module cfgp_keyed_port_tb;
    localparam logic [15:0] BASE = 16'h002E;
    localparam int NL = 16;
    localparam logic [15:0] DID = 16'h5A31;
    localparam logic [7:0]  DRV = 8'h03;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0] io_wdata = 8'h0;
    logic [7:0] io_rdata, cur_ldn, dev_addr, dev_wdata, dev_rdata;
    logic cfg_open, dev_wr, dev_rd;
    logic [NL-1:0] ldn_enable;

    int total = 0, bad = 0;
    // reference model state
    int m_st = 0;               // 0 closed, 1 half key, 2 open
    logic [7:0] m_idx = 8'h00, m_ldn = 8'h00;
    logic [NL-1:0] m_en = '0;

    always #2 clk = ~clk;       // 250 MHz

    assign dev_rdata = dev_addr ^ {cur_ldn[3:0], 4'h5};

    cfgp_keyed_port u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_open(cfg_open),
        .cur_ldn(cur_ldn), .ldn_enable(ldn_enable), .dev_wr(dev_wr), .dev_rd(dev_rd),
        .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [15:0] a);
        if (a == BASE) return (m_st == 2) ? m_idx : 8'hFF;
        if (a != BASE + 16'd1) return 8'h00;
        if (m_st != 2) return 8'hFF;
        if (m_idx >= 8'h31) return m_idx ^ {m_ldn[3:0], 4'h5};
        case (m_idx)
            8'h07: return m_ldn;
            8'h20: return DID[15:8];
            8'h21: return DID[7:0];
            8'h22: return DRV;
            8'h23: return 8'h19;
            8'h24: return 8'h34;
            8'h30: return (m_ldn < NL) ? {7'd0, m_en[m_ldn[3:0]]} : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
        #1;
        chk("R10 dev_wr", dev_wr, (m_st == 2 && a == BASE + 16'd1 && m_idx >= 8'h31));
        @(posedge clk);
        if (a == BASE) begin
            if (m_st != 2) m_st = (d == 8'h87) ? ((m_st == 1) ? 2 : 1) : 0;
            else if (d == 8'hAA) m_st = 0;
            else m_idx = d;
        end else if (a == BASE + 16'd1) begin
            if (m_st == 1) m_st = 0;
            else if (m_st == 2) begin
                if (m_idx == 8'h07) m_ldn = d;
                if (m_idx == 8'h30 && m_ldn < NL) m_en[m_ldn[3:0]] = d[0];
            end
        end
        #1 io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input string req);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1; io_wr = 1'b0;
        #1;
        chk(req, io_rdata, exp_read(a));
        chk("R10 dev_rd", dev_rd, (m_st == 2 && a == BASE + 16'd1 && m_idx >= 8'h31));
        @(posedge clk);
        if (a == BASE + 16'd1 && m_st == 1) m_st = 0;
        #1 io_rd = 1'b0;
    endtask

    task automatic state_chk(input string req);
        @(negedge clk);
        chk({req, " open"}, cfg_open, (m_st == 2));
        chk({req, " ldn"}, cur_ldn, m_ldn);
        chk({req, " en"}, ldn_enable, m_en);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        state_chk("R1");
        rd(BASE + 16'd1, "R1 closed read");
        // R5 closed writes ignored
        wr(BASE + 16'd1, 8'h5C);
        rd(BASE, "R5 closed index read");
        state_chk("R5");
        // R3 single key then other value
        wr(BASE, 8'h87); wr(BASE, 8'h07); state_chk("R3 single key");
        // R3 key, data access, key
        wr(BASE, 8'h87); rd(BASE + 16'd1, "R3 data between"); wr(BASE, 8'h87);
        state_chk("R3 interrupted");
        // R2 proper unlock
        wr(BASE, 8'h87); wr(BASE, 8'h87); state_chk("R2 unlocked");
        // R6/R7 bank 7
        wr(BASE, 8'h07); rd(BASE, "R6 index read");
        wr(BASE + 16'd1, 8'h07); rd(BASE + 16'd1, "R7 ldn read"); state_chk("R7");
        // R9 enable watchdog bank
        wr(BASE, 8'h30); wr(BASE + 16'd1, 8'hFF); rd(BASE + 16'd1, "R9 enable"); state_chk("R9");
        // R8 ids and ignored writes
        for (int i = 8'h20; i <= 8'h24; i++) begin
            wr(BASE, 8'(i)); wr(BASE + 16'd1, 8'h00); rd(BASE + 16'd1, "R8 id");
        end
        // R9 out of range bank
        wr(BASE, 8'h07); wr(BASE + 16'd1, 8'h13);
        wr(BASE, 8'h30); wr(BASE + 16'd1, 8'h01); rd(BASE + 16'd1, "R9 oob"); state_chk("R9 oob");
        // R10 boundary
        wr(BASE, 8'h31); wr(BASE + 16'd1, 8'h11); rd(BASE + 16'd1, "R10 fwd 31");
        wr(BASE, 8'h2F); wr(BASE + 16'd1, 8'h11); rd(BASE + 16'd1, "R11 global 2f");
        // R11 other address
        rd(16'h004E, "R11 other addr"); wr(16'h004F, 8'h01); state_chk("R11");
        // R4 lock keeps index, then reopen
        wr(BASE, 8'hAA); state_chk("R4 locked"); rd(BASE, "R4 closed idx");
        wr(BASE, 8'h87); wr(BASE, 8'h87); rd(BASE, "R4 index kept");
        // random mix
        for (int n = 0; n < 3000; n++) begin
            int k;
            logic [15:0] a;
            logic [7:0] d;
            k = int'($urandom_range(0, 9));
            a = (k < 4) ? BASE : (k < 9) ? BASE + 16'd1 : 16'h0061;
            case ($urandom_range(0, 7))
                0, 1: d = 8'h87;
                2: d = 8'hAA;
                3: d = 8'h07;
                4: d = 8'(8'h20 + $urandom_range(0, 4));
                5: d = 8'h30;
                6: d = 8'($urandom_range(0, 19));
                default: d = 8'($urandom);
            endcase
            if ($urandom_range(0, 1) == 0) wr(a, d);
            else rd(a, "R6 R7 R8 R9 R10 random read");
            if (n % 50 == 0) state_chk("R2 R7 R9 random");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule